// File: doc/BRIEF.md
# Superscalar Pipeline Stage with Skid-Buffer Stall Control

This block is one stage of a superscalar in-order pipeline. It sits between a producer stage (upstream) that delivers up to `IN_W` instruction slots per cycle and a consumer stage (downstream) that accepts up to `OUT_W` slots per cycle. Slots are opaque payloads that carry a kill bit. Killed slots are dropped and use no output bandwidth. The stage forwards slots in arrival order and emits them on the same cycle they become eligible.

A five-state controller governs the flow: Idle, Running, Blocked, Unblocking and Squashing. When the consumer raises a stall, or when more live slots arrive than can be forwarded, the pending slots move into a skid buffer. The stage then asks the producer to hold off. Once the stall is gone, the buffer is emptied oldest first, and only after it is empty does the stage tell the producer to resume. A flush request from the retirement logic discards everything in flight and overrides any stall. Five saturating counters record how many cycles the controller spends in each state.

Top module: `skid_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stage_state` reads 0 (Idle), `out_valid`, `up_block` and `up_unblock` are low and every `cyc_count` entry is 0. State codes are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: Live slots leave in arrival order (lower input index first within a cycle), packed from output slot 0, at most `OUT_W` per cycle. A slot whose kill bit is set is discarded without taking an output position.
- R3: In Idle or Running, if slots remain after `OUT_W` live slots have been forwarded, the remainder is kept in the skid buffer, the state becomes Blocked and `up_block` is high for that cycle. `up_block` and `up_unblock` are never high together.
- R4: `dn_block` records a stall that lasts until a cycle with `dn_unblock` high (unblock wins if both are high). While stalled, nothing is forwarded, all valid input slots are appended to the skid buffer in arrival order, and `up_block` is raised only in the cycle the state enters Blocked from another state.
- R5: In Blocked with a non-empty buffer and no stall, the stage drains up to `OUT_W` live slots from the buffer head in that cycle and moves to Unblocking. Slots arriving meanwhile queue behind the buffered ones.
- R6: `up_unblock` is raised, and the state goes to Running, only in a cycle that leaves the skid buffer empty.
- R7: If a Blocked stage with an empty buffer would resume (and so raise `up_unblock`) in a cycle that also leaves slots over, neither `up_block` nor `up_unblock` is raised and the state stays Blocked.
- R8: `commit_squash` takes priority over any stall. In that cycle nothing is forwarded, the buffer and the current inputs are discarded, and the next state is Squashing. `up_unblock` is raised if the state was Blocked or Unblocking, and is not raised otherwise.
- R9: From Squashing, a cycle with no squash and no stall forwards input as Running does. The next state is Running if nothing is left over, and Blocked otherwise.
- R10: The skid buffer holds `(UP_DELAY+1)*IN_W` entries. A full buffer drains correctly, and the contents never exceed that depth when the producer honours `up_block`.
- R11: `cyc_count[k]` counts the clock edges at which the state code was k, and it saturates at all ones.
- R12: `dn_unblock` is high only while a stall is recorded (a protocol rule on the consumer side).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | IN_W | Per-slot valid from the producer |
| in_kill | input | IN_W | Per-slot kill bit |
| in_data | input | IN_W*DATA_W | Slot payloads |
| dn_block | input | 1 | Consumer stall request |
| dn_unblock | input | 1 | Consumer stall release |
| commit_squash | input | 1 | Flush request from retirement |
| out_valid | output | OUT_W | Forwarded slot valid, packed from slot 0 |
| out_data | output | OUT_W*DATA_W | Forwarded payloads |
| up_block | output | 1 | Hold request to the producer |
| up_unblock | output | 1 | Resume notice to the producer |
| stage_state | output | 3 | Current controller state code |
| cyc_count | output | 5*CNT_W | Per-state cycle counters, indexed by state code |

## Verification
The hardest situation to reach is the withdrawn handshake. It needs a Blocked state with an empty buffer, a stall that clears, and more live input than the output width, all in the same cycle. The stimulus gets there by raising a stall with no input present, then releasing it in the next cycle together with a full row of live slots. A scoreboard queue checks that every live payload emerges exactly once and in order across stalls, partial drains, late arrivals during Unblocking and flushes. A flush empties the queue, because the block discards everything still pending at that point.

// File: rtl/stage_pkg.sv
package stage_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCKED = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } stage_state_e;

    localparam int NUM_STATES = 5;

    typedef struct packed {
        logic up_block;
        logic up_unblock;
        logic flush;
    } stage_ctl_t;

    // States in which the producer has been told to hold off
    function automatic logic is_held(input stage_state_e s);
        return (s == ST_BLOCKED) || (s == ST_UNBLOCK);
    endfunction

endpackage

// File: rtl/stage_select.sv
module stage_select #(
    parameter int TOTAL  = 12,
    parameter int OUT_W  = 2,
    parameter int DATA_W = 16,
    parameter int CW     = 4
) (
    input  logic                   src_kill [TOTAL],
    input  logic [DATA_W-1:0]      src_data [TOTAL],
    input  logic [CW-1:0]          limit,
    output logic [OUT_W-1:0]       out_valid,
    output logic [OUT_W-1:0][DATA_W-1:0] out_data,
    output logic [CW-1:0]          popped
);
    localparam int FW = $clog2(OUT_W + 1);
    localparam int OW = (OUT_W > 1) ? $clog2(OUT_W) : 1;

    logic [FW-1:0] n;

    // Walk the list head-first; killed entries are consumed for free
    always_comb begin
        out_valid = '0;
        out_data  = '0;
        popped    = '0;
        n         = '0;
        for (int i = 0; i < TOTAL; i++) begin
            if ((CW'(i) < limit) && (n < FW'(OUT_W))) begin
                popped = CW'(i + 1);
                if (!src_kill[i]) begin
                    out_valid[n[OW-1:0]] = 1'b1;
                    out_data[n[OW-1:0]]  = src_data[i];
                    n = n + FW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/stage_skid.sv
module stage_skid #(
    parameter int DEPTH  = 8,
    parameter int TOTAL  = 12,
    parameter int DATA_W = 16,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              src_kill [TOTAL],
    input  logic [DATA_W-1:0] src_data [TOTAL],
    input  logic [CW-1:0]     popped,
    input  logic [CW-1:0]     rem,
    output logic              skid_kill [DEPTH],
    output logic [DATA_W-1:0] skid_data [DEPTH],
    output logic [CW-1:0]     skid_cnt
);
    localparam int IW = $clog2(TOTAL);

    logic              nxt_kill [DEPTH];
    logic [DATA_W-1:0] nxt_data [DEPTH];
    logic [CW:0]       sel;

    // Next contents: the combined list shifted by the popped count
    always_comb begin
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sel = {1'b0, popped} + (CW+1)'(i);
            if (sel < (CW+1)'(TOTAL)) begin
                nxt_kill[i] = src_kill[sel[IW-1:0]];
                nxt_data[i] = src_data[sel[IW-1:0]];
            end else begin
                nxt_kill[i] = 1'b0;
                nxt_data[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        skid_cnt <= '0;
        else if (flush) skid_cnt <= '0;
        else            skid_cnt <= rem;
    end

    always_ff @(posedge clk) begin
        skid_kill <= nxt_kill;
        skid_data <= nxt_data;
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!flush |-> (rem <= CW'(DEPTH))));
endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
    import stage_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         squash,
    input  logic         stall,
    input  logic         skid_empty,
    input  logic         rem_zero,
    output stage_ctl_t   ctl,
    output logic         drain,
    output stage_state_e state_q
);
    stage_state_e state_d;
    logic         unb_pend;

    assign drain    = (state_q == ST_UNBLOCK) || ((state_q == ST_BLOCKED) && !skid_empty);
    assign unb_pend = (state_q == ST_BLOCKED) && skid_empty;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        if (squash) begin
            ctl.flush      = 1'b1;
            ctl.up_unblock = is_held(state_q);
            state_d        = ST_SQUASH;
        end else if (stall) begin
            state_d      = ST_BLOCKED;
            ctl.up_block = (state_q != ST_BLOCKED);
        end else if (drain) begin
            if (rem_zero) begin
                state_d        = ST_RUN;
                ctl.up_unblock = 1'b1;
            end else begin
                state_d = ST_UNBLOCK;
            end
        end else if (rem_zero) begin
            state_d        = (state_q == ST_IDLE) ? ST_IDLE : ST_RUN;
            ctl.up_unblock = unb_pend;
        end else begin
            // leftovers: a resume notice pending this cycle is withdrawn instead
            state_d      = ST_BLOCKED;
            ctl.up_block = !unb_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    a_r3_handshake_excl: assert property (@(posedge clk) disable iff (rst)
        !(ctl.up_block && ctl.up_unblock));
    a_r4_block_on_entry: assert property (@(posedge clk) disable iff (rst)
        ctl.up_block |-> (state_q != ST_BLOCKED));
    a_r4_block_lands: assert property (@(posedge clk) disable iff (rst)
        ctl.up_block |=> (state_q == ST_BLOCKED));
    a_r8_squash_state: assert property (@(posedge clk) disable iff (rst)
        squash |=> (state_q == ST_SQUASH));
    a_r9_leave_squash: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SQUASH) && !squash && !stall) |=>
            ((state_q == ST_RUN) || (state_q == ST_BLOCKED)));
endmodule

// File: rtl/stage_cyc_cnt.sv
module stage_cyc_cnt #(
    parameter int NUM   = 5,
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 state,
    output logic [NUM-1:0][CNT_W-1:0]  cnt
);
    for (genvar k = 0; k < NUM; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)                         cnt[k] <= '0;
            else if (state == 3'(k) && cnt[k] != '1) cnt[k] <= cnt[k] + CNT_W'(1);
        end

        a_r11_saturate: assert property (@(posedge clk) disable iff (rst)
            (cnt[k] == '1) |=> (cnt[k] == '1));
    end
endmodule

// File: rtl/skid_stage.sv
module skid_stage
    import stage_pkg::*;
#(
    parameter int IN_W     = 4,
    parameter int OUT_W    = 2,
    parameter int DATA_W   = 16,
    parameter int UP_DELAY = 1,
    parameter int CNT_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [IN_W-1:0]                   in_valid,
    input  logic [IN_W-1:0]                   in_kill,
    input  logic [IN_W-1:0][DATA_W-1:0]       in_data,
    input  logic                              dn_block,
    input  logic                              dn_unblock,
    input  logic                              commit_squash,
    output logic [OUT_W-1:0]                  out_valid,
    output logic [OUT_W-1:0][DATA_W-1:0]      out_data,
    output logic                              up_block,
    output logic                              up_unblock,
    output logic [2:0]                        stage_state,
    output logic [NUM_STATES-1:0][CNT_W-1:0]  cyc_count
);
    localparam int DEPTH = (UP_DELAY + 1) * IN_W;
    localparam int TOTAL = DEPTH + IN_W;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int IW    = $clog2(TOTAL);

    logic              stall_q, stall_eff;
    logic              skid_kill [DEPTH];
    logic [DATA_W-1:0] skid_data [DEPTH];
    logic [CW-1:0]     skid_cnt;
    logic              cmb_kill [TOTAL];
    logic [DATA_W-1:0] cmb_data [TOTAL];
    logic [CW-1:0]     cmb_cnt, idx, limit, popped, rem;
    stage_ctl_t        ctl;
    logic              drain;
    stage_state_e      state_q;

    assign stall_eff = (stall_q | dn_block) & ~dn_unblock;

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= stall_eff;
    end

    // Buffered entries first, then this cycle's valid slots in index order
    always_comb begin
        for (int i = 0; i < TOTAL; i++) begin
            cmb_kill[i] = 1'b0;
            cmb_data[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            cmb_kill[i] = skid_kill[i];
            cmb_data[i] = skid_data[i];
        end
        idx = skid_cnt;
        for (int j = 0; j < IN_W; j++) begin
            if (in_valid[j]) begin
                cmb_kill[idx[IW-1:0]] = in_kill[j];
                cmb_data[idx[IW-1:0]] = in_data[j];
                idx = idx + CW'(1);
            end
        end
        cmb_cnt = idx;
    end

    assign limit = (commit_squash || stall_eff) ? '0 : (drain ? skid_cnt : cmb_cnt);
    assign rem   = cmb_cnt - popped;

    stage_select #(.TOTAL(TOTAL), .OUT_W(OUT_W), .DATA_W(DATA_W), .CW(CW)) u_select (
        .src_kill (cmb_kill),
        .src_data (cmb_data),
        .limit    (limit),
        .out_valid(out_valid),
        .out_data (out_data),
        .popped   (popped)
    );

    stage_skid #(.DEPTH(DEPTH), .TOTAL(TOTAL), .DATA_W(DATA_W), .CW(CW)) u_skid (
        .clk      (clk),
        .rst      (rst),
        .flush    (ctl.flush),
        .src_kill (cmb_kill),
        .src_data (cmb_data),
        .popped   (popped),
        .rem      (rem),
        .skid_kill(skid_kill),
        .skid_data(skid_data),
        .skid_cnt (skid_cnt)
    );

    stage_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .squash    (commit_squash),
        .stall     (stall_eff),
        .skid_empty(skid_cnt == '0),
        .rem_zero  (rem == '0),
        .ctl       (ctl),
        .drain     (drain),
        .state_q   (state_q)
    );

    stage_cyc_cnt #(.NUM(NUM_STATES), .CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .state(state_q),
        .cnt  (cyc_count)
    );

    assign up_block    = ctl.up_block;
    assign up_unblock  = ctl.up_unblock;
    assign stage_state = state_q;

    a_r2_packed_out: assert property (@(posedge clk) disable iff (rst)
        (((out_valid + OUT_W'(1)) & out_valid) == '0));
    a_r4_quiet_stall: assert property (@(posedge clk) disable iff (rst)
        stall_eff |-> (out_valid == '0));
    a_r8_quiet_flush: assert property (@(posedge clk) disable iff (rst)
        commit_squash |=> (skid_cnt == '0));
    a_r6_unblock_empty: assert property (@(posedge clk) disable iff (rst)
        (up_unblock && !commit_squash) |=> ((skid_cnt == '0) && (stage_state == 3'd1)));
    a_r12_unblock_proto: assert property (@(posedge clk) disable iff (rst)
        dn_unblock |-> stall_q);
endmodule

// File: tb/skid_stage_tb.sv
`timescale 1ns/1ps
module skid_stage_tb;
    localparam int IN_W = 4, OUT_W = 2, DW = 16, CNT_W = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic [IN_W-1:0] in_valid = '0, in_kill = '0;
    logic [IN_W-1:0][DW-1:0] in_data = '0;
    logic dn_block = 1'b0, dn_unblock = 1'b0, commit_squash = 1'b0;
    logic [OUT_W-1:0] out_valid;
    logic [OUT_W-1:0][DW-1:0] out_data;
    logic up_block, up_unblock;
    logic [2:0] stage_state;
    logic [4:0][CNT_W-1:0] cyc_count;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] next_id = 16'h0100;

    always #2.5 clk = ~clk;

    skid_stage u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kill(in_kill), .in_data(in_data),
        .dn_block(dn_block), .dn_unblock(dn_unblock), .commit_squash(commit_squash),
        .out_valid(out_valid), .out_data(out_data), .up_block(up_block),
        .up_unblock(up_unblock), .stage_state(stage_state), .cyc_count(cyc_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares every forwarded slot with the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            for (int j = 0; j < OUT_W; j++) begin
                if (out_valid[j]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R2 R5 unexpected slot actual=%0h expected=none", out_data[j]);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        if (out_data[j] !== e) begin
                            errors++;
                            $display("FAIL R2 R5 order actual=%0h expected=%0h", out_data[j], e);
                        end
                    end
                end
            end
        end
    end

    // Driver: one cycle of stimulus, returns just after the sampling edge
    task automatic step(input logic [IN_W-1:0] v, input logic [IN_W-1:0] k,
                        input logic blk, input logic unb, input logic sq);
        @(posedge clk); #1;
        in_valid = v; in_kill = k;
        dn_block = blk; dn_unblock = unb; commit_squash = sq;
        if (sq) exp_q.delete();
        for (int j = 0; j < IN_W; j++) begin
            in_data[j] = next_id;
            if (v[j] && !k[j] && !sq) exp_q.push_back(next_id);
            next_id = next_id + 16'd1;
        end
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset state", 64'(stage_state), 64'd0);
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset handshakes", 64'({up_block, up_unblock}), 64'd0);
        chk("R1 reset counter", 64'(cyc_count[0]), 64'd0);
        rst = 1'b0;

        // R11 counting
        step('0, '0, 0, 0, 0);
        chk("R1 state after reset", 64'(stage_state), 64'd0);
        step('0, '0, 0, 0, 0);
        step('0, '0, 0, 0, 0);
        chk("R11 idle count", 64'(cyc_count[0]), 64'd3);
        step('0, '0, 1, 0, 0);
        chk("R4 block from idle", 64'(up_block), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R4 no repeat block", 64'(up_block), 64'd0);
        chk("R4 blocked state", 64'(stage_state), 64'd2);
        step('0, '0, 0, 1, 0);
        chk("R6 unblock empty skid", 64'(up_unblock), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R6 running", 64'(stage_state), 64'd1);
        chk("R11 idle total", 64'(cyc_count[0]), 64'd5);
        chk("R11 blocked total", 64'(cyc_count[2]), 64'd2);
        chk("R11 run total", 64'(cyc_count[1]), 64'd0);

        // R2 plain forwarding and killed slots
        step(4'b0011, '0, 0, 0, 0);
        chk("R2 two live out", 64'(out_valid), 64'b11);
        step(4'b1111, 4'b0101, 0, 0, 0);
        chk("R2 kill frees bandwidth", 64'(out_valid), 64'b11);
        chk("R2 no block", 64'(up_block), 64'd0);

        // R3 overflow of output width
        step(4'b1111, '0, 0, 0, 0);
        chk("R3 leftover blocks", 64'(up_block), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R3 blocked", 64'(stage_state), 64'd2);
        chk("R6 drained unblock", 64'(up_unblock), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R6 back to run", 64'(stage_state), 64'd1);

        // R4 / R5 stall, in-flight arrivals, drain
        step(4'b1111, '0, 1, 0, 0);
        chk("R4 stall no output", 64'(out_valid), 64'd0);
        chk("R4 block on entry", 64'(up_block), 64'd1);
        step(4'b0011, '0, 0, 0, 0);
        chk("R4 held no output", 64'(out_valid), 64'd0);
        chk("R4 no second block", 64'(up_block), 64'd0);
        step('0, '0, 0, 1, 0);
        chk("R5 drain two", 64'(out_valid), 64'b11);
        chk("R6 no early unblock", 64'(up_unblock), 64'd0);
        step(4'b0001, '0, 0, 0, 0);
        chk("R5 unblocking", 64'(stage_state), 64'd3);
        step('0, '0, 0, 0, 0);
        chk("R6 still draining", 64'(up_unblock), 64'd0);
        step('0, '0, 0, 0, 0);
        chk("R6 last slot unblocks", 64'(up_unblock), 64'd1);
        chk("R5 single tail slot", 64'(out_valid), 64'b01);
        step('0, '0, 0, 0, 0);
        chk("R6 running again", 64'(stage_state), 64'd1);

        // R7 withdrawn handshake
        step('0, '0, 1, 0, 0);
        chk("R7 setup block", 64'(up_block), 64'd1);
        step(4'b1111, '0, 0, 1, 0);
        chk("R7 neither handshake", 64'({up_block, up_unblock}), 64'd0);
        step('0, '0, 0, 0, 0);
        chk("R7 stays blocked", 64'(stage_state), 64'd2);
        chk("R7 later unblock", 64'(up_unblock), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R7 running", 64'(stage_state), 64'd1);

        // R8 / R9 flush while blocked
        step(4'b1111, '0, 1, 0, 0);
        step(4'b0011, '0, 0, 1, 1);
        chk("R8 unblock on flush from blocked", 64'(up_unblock), 64'd1);
        chk("R8 no output on flush", 64'(out_valid), 64'd0);
        step(4'b0011, '0, 0, 0, 0);
        chk("R8 squashing", 64'(stage_state), 64'd4);
        chk("R9 forwards from squash", 64'(out_valid), 64'b11);
        step('0, '0, 0, 0, 0);
        chk("R9 running after squash", 64'(stage_state), 64'd1);

        // R8 flush beats stall, from running
        step(4'b0011, '0, 1, 0, 1);
        chk("R8 no unblock from running", 64'({up_block, up_unblock}), 64'd0);
        chk("R8 priority no output", 64'(out_valid), 64'd0);
        step('0, '0, 0, 0, 0);
        chk("R8 squashing again", 64'(stage_state), 64'd4);
        chk("R4 recorded stall blocks", 64'(up_block), 64'd1);
        step('0, '0, 0, 1, 0);
        chk("R6 resume", 64'(up_unblock), 64'd1);

        // R10 fill buffer to capacity
        step(4'b1111, '0, 1, 0, 0);
        step(4'b1111, '0, 0, 0, 0);
        step('0, '0, 0, 1, 0);
        chk("R10 full drain starts", 64'(out_valid), 64'b11);
        step('0, '0, 0, 0, 0);
        step('0, '0, 0, 0, 0);
        chk("R10 not yet empty", 64'(up_unblock), 64'd0);
        step('0, '0, 0, 0, 0);
        chk("R10 emptied", 64'(up_unblock), 64'd1);
        step('0, '0, 0, 0, 0);
        chk("R10 running", 64'(stage_state), 64'd1);
        chk("R5 scoreboard empty", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule